// File: doc/BRIEF.md
# Exact squared-distance front end with float output

This block takes two points in three dimensions, each coordinate an unsigned fixed-point integer, and produces the squared distance between them as an IEEE single-precision word. Every arithmetic step before the final format change is done in fixed point at full width, so nothing is rounded. The per-axis absolute differences, their squares and the three-term total are all exact. The final stage finds the leading one of the total, sets the exponent from its position and left-aligns the bits below it into the fraction field. A square root, or any other floating-point operator, can take the result directly.

The datapath is a four-stage pipeline: absolute difference, square, sum, convert. One new point pair may enter on every clock. A strobe travels alongside each pair and marks the matching result. The converter sorts each total into one of two classes, a zero total or a nonzero total, and picks the output encoding from that class. A parameter sets where the binary point lies in the coordinate scale. It shifts the exponent and leaves the fraction unchanged.

Top module: `sqdist_fp_front`

## Requirements
- R1: For each axis, the difference that is squared is the absolute value of the difference between the two coordinates. Swapping the two points gives the same output word.
- R2: The total is the exact sum of the three squared differences. With 11-bit coordinates the worst case is 3 × 2047² = 12,570,627, and it is represented without overflow or loss.
- R3: For a nonzero total whose leading one is at bit position p, output bits 30:23 hold 127 + p − POINT_POS. POINT_POS defaults to 0.
- R4: For a nonzero total, output bits 22:0 hold the bits below the leading one, left-aligned with zero fill, and no rounding is applied.
- R5: A zero total, meaning the two points are identical, gives the output word 32'h0000_0000.
- R6: Output bit 31, the sign, is always 0 whenever out_valid is high.
- R7: out_valid equals in_valid as it was sampled four rising edges earlier, and each valid input produces exactly one valid output.
- R8: An active-low asynchronous reset clears out_valid and out_word to 0 and discards every pair in flight.
- R9: Pairs presented on consecutive cycles, or with idle gaps between them, each give their own independent result in input order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks a point pair to process |
| ax | input | COORD_W | First point, x coordinate |
| ay | input | COORD_W | First point, y coordinate |
| az | input | COORD_W | First point, z coordinate |
| bx | input | COORD_W | Second point, x coordinate |
| by | input | COORD_W | Second point, y coordinate |
| bz | input | COORD_W | Second point, z coordinate |
| out_valid | output | 1 | Marks a result on out_word |
| out_word | output | 32 | Squared distance in single-precision encoding |

## Verification
The assertions check several properties on every cycle:
- the strobe reaches the output after exactly four edges;
- the sign bit is clear on every valid result;
- a zero total gives the all-zero word;
- the exponent stays within the range the total's width allows;
- the normalising shift always places a one at the top;
- each per-axis difference added to the smaller coordinate gives back the larger one;
- the stored total is never smaller than any one of its squares.

Only the bench's scenarios can show the exact bit pattern of each result. These scenarios cover exact powers of two, the largest total, swapped operand order, streams with gaps, and the dropping of in-flight pairs when reset is applied during a run.

// File: rtl/sqdist_pkg.sv
package sqdist_pkg;
    localparam int FP_EXP_W = 8;
    localparam int FP_MAN_W = 23;
    localparam int FP_BIAS  = 127;

    typedef enum logic {
        SUM_ZERO    = 1'b0,
        SUM_NONZERO = 1'b1
    } sum_class_e;
endpackage

// File: rtl/sqdist_absdiff.sv
module sqdist_absdiff #(
    parameter int W = 11
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] d
);
    always_comb begin
        if (a >= b) d = a - b;
        else        d = b - a;
    end

    // Adding the difference to the smaller operand must give back the larger one.
    always_comb begin
        assert_absdiff_R1: assert ((W+1)'(d) + (W+1)'((a < b) ? a : b) == (W+1)'((a < b) ? b : a));
    end
endmodule

// File: rtl/sqdist_square.sv
module sqdist_square #(
    parameter int W = 11
) (
    input  logic [W-1:0]   d,
    output logic [2*W-1:0] p
);
    always_comb p = (2*W)'(d) * (2*W)'(d);
endmodule

// File: rtl/sqdist_to_float.sv
module sqdist_to_float
    import sqdist_pkg::*;
#(
    parameter int SUM_W     = 24,
    parameter int POINT_POS = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [SUM_W-1:0] sum,
    output logic             out_vld,
    output logic [31:0]      out_word
);
    localparam int LZ_W    = $clog2(SUM_W + 1);
    localparam int EXP_TOP = FP_BIAS - POINT_POS + SUM_W - 1;
    localparam int EXP_LOW = FP_BIAS - POINT_POS;

    function automatic logic [LZ_W-1:0] lead_zeros(input logic [SUM_W-1:0] v);
        logic [LZ_W-1:0] n;
        logic            seen;
        n    = '0;
        seen = 1'b0;
        for (int i = SUM_W - 1; i >= 0; i--) begin
            if (!seen) begin
                if (v[i]) seen = 1'b1;
                else      n    = n + 1'b1;
            end
        end
        return n;
    endfunction

    sum_class_e          cls;
    logic [LZ_W-1:0]     lz;
    logic [SUM_W-1:0]    aligned;
    logic [FP_EXP_W-1:0] exp_f;
    logic [FP_MAN_W-1:0] frac_f;
    logic [31:0]         word_c;

    always_comb begin
        cls     = (sum == '0) ? SUM_ZERO : SUM_NONZERO;
        lz      = lead_zeros(sum);
        aligned = sum << lz;
        exp_f   = FP_EXP_W'(EXP_TOP - int'(lz));
    end

    generate
        if (SUM_W - 1 >= FP_MAN_W) begin : g_frac_cut
            assign frac_f = aligned[SUM_W-2 -: FP_MAN_W];
        end else begin : g_frac_pad
            assign frac_f = {aligned[SUM_W-2:0], {(FP_MAN_W - SUM_W + 1){1'b0}}};
        end
    endgenerate

    always_comb begin
        unique case (cls)
            SUM_ZERO:    word_c = 32'h0;
            SUM_NONZERO: word_c = {1'b0, exp_f, frac_f};
            default:     word_c = 32'h0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_word <= 32'h0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) out_word <= word_c;
        end
    end

    // The normalising shift must leave a one in the top bit for a nonzero total.
    always_comb begin
        if (in_vld && sum != '0) begin
            assert_lead_one_R4: assert (aligned[SUM_W-1]);
        end
    end

    assert_zero_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && sum == '0) |=> (out_word == 32'h0));

    assert_exp_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && sum != '0) |=> (int'(out_word[30:23]) >= EXP_LOW &&
                                   int'(out_word[30:23]) <= EXP_TOP));
endmodule

// File: rtl/sqdist_fp_front.sv
module sqdist_fp_front #(
    parameter int COORD_W   = 11,
    parameter int POINT_POS = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [COORD_W-1:0] ax,
    input  logic [COORD_W-1:0] ay,
    input  logic [COORD_W-1:0] az,
    input  logic [COORD_W-1:0] bx,
    input  logic [COORD_W-1:0] by,
    input  logic [COORD_W-1:0] bz,
    output logic               out_valid,
    output logic [31:0]        out_word
);
    localparam int AXES  = 3;
    localparam int SQ_W  = 2 * COORD_W;
    localparam int SUM_W = SQ_W + 2;

    logic [COORD_W-1:0] pa [AXES];
    logic [COORD_W-1:0] pb [AXES];
    logic [COORD_W-1:0] diff_c [AXES];
    logic [COORD_W-1:0] s1_d [AXES];
    logic [SQ_W-1:0]    sq_c [AXES];
    logic [SQ_W-1:0]    s2_sq [AXES];
    logic [SUM_W-1:0]   s3_sum;
    logic               s1_v, s2_v, s3_v;

    always_comb begin
        pa[0] = ax; pa[1] = ay; pa[2] = az;
        pb[0] = bx; pb[1] = by; pb[2] = bz;
    end

    generate
        for (genvar g = 0; g < AXES; g++) begin : g_axis
            sqdist_absdiff #(.W(COORD_W)) u_diff (
                .a (pa[g]),
                .b (pb[g]),
                .d (diff_c[g])
            );
            sqdist_square #(.W(COORD_W)) u_sq (
                .d (s1_d[g]),
                .p (sq_c[g])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v   <= 1'b0;
            s2_v   <= 1'b0;
            s3_v   <= 1'b0;
            s3_sum <= '0;
            for (int i = 0; i < AXES; i++) begin
                s1_d[i]  <= '0;
                s2_sq[i] <= '0;
            end
        end else begin
            s1_v <= in_valid;
            s2_v <= s1_v;
            s3_v <= s2_v;
            for (int i = 0; i < AXES; i++) begin
                if (in_valid) s1_d[i]  <= diff_c[i];
                if (s1_v)     s2_sq[i] <= sq_c[i];
            end
            if (s2_v) s3_sum <= SUM_W'(s2_sq[0]) + SUM_W'(s2_sq[1]) + SUM_W'(s2_sq[2]);
        end
    end

    sqdist_to_float #(.SUM_W(SUM_W), .POINT_POS(POINT_POS)) u_conv (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (s3_v),
        .sum      (s3_sum),
        .out_vld  (out_valid),
        .out_word (out_word)
    );

    // Checker state: edges seen since reset, saturating at the pipeline depth.
    logic [2:0] warm;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            warm <= '0;
        else if (warm != 3'd4) warm <= warm + 3'd1;
    end

    assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 3'd4) |-> (out_valid == $past(in_valid, 4)));

    assert_sign_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_word[31]);

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s2_v |=> (s3_sum >= SUM_W'($past(s2_sq[0])) &&
                  s3_sum >= SUM_W'($past(s2_sq[1])) &&
                  s3_sum >= SUM_W'($past(s2_sq[2]))));
endmodule

// File: tb/sqdist_fp_front_bench.sv
module sqdist_fp_front_bench;
    localparam int W = 11;

    typedef struct {
        bit        v;
        bit [31:0] w;
        string     tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] ax = '0, ay = '0, az = '0, bx = '0, by = '0, bz = '0;
    logic         out_valid;
    logic [31:0]  out_word;

    int   total = 0;
    int   bad = 0;
    exp_t q[$];

    always #10 clk = ~clk;

    sqdist_fp_front #(.COORD_W(W), .POINT_POS(0)) u_sqdist_fp_front (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .ax(ax), .ay(ay), .az(az), .bx(bx), .by(by), .bz(bz),
        .out_valid(out_valid), .out_word(out_word)
    );

    function automatic bit [31:0] ref_word(int a0, int a1, int a2, int b0, int b1, int b2);
        longint s, d;
        int p;
        longint e, f;
        d = (a0 > b0) ? a0 - b0 : b0 - a0; s  = d * d;
        d = (a1 > b1) ? a1 - b1 : b1 - a1; s += d * d;
        d = (a2 > b2) ? a2 - b2 : b2 - a2; s += d * d;
        if (s == 0) return 32'h0;
        p = 0;
        while ((s >> (p + 1)) != 0) p++;
        e = 127 + p;
        f = (s << (23 - p)) & 64'h7F_FFFF;
        return {1'b0, e[7:0], f[22:0]};
    endfunction

    task automatic check(string req, bit [31:0] act, bit [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic prefill();
        q.delete();
        for (int i = 0; i < 4; i++) q.push_back('{v: 1'b0, w: 32'h0, tag: "R7"});
    endtask

    // One clock: compare the oldest expectation, then drive the next input.
    task automatic tick(bit v, int a0, int a1, int a2, int b0, int b1, int b2, string tag);
        exp_t e;
        @(negedge clk);
        e = q.pop_front();
        check("R7 valid", {31'b0, out_valid}, {31'b0, e.v});
        if (e.v && out_valid) begin
            check(e.tag, out_word, e.w);
            check("R6 sign", {31'b0, out_word[31]}, 32'h0);
            check("R3 exponent", {24'b0, out_word[30:23]}, {24'b0, e.w[30:23]});
            check("R4 fraction", {9'b0, out_word[22:0]}, {9'b0, e.w[22:0]});
        end
        in_valid = v;
        ax = W'(a0); ay = W'(a1); az = W'(a2);
        bx = W'(b0); by = W'(b1); bz = W'(b2);
        q.push_back('{v: v, w: v ? ref_word(a0, a1, a2, b0, b1, b2) : 32'h0, tag: tag});
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick(1'b0, 0, 0, 0, 0, 0, 0, "R7");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset valid", {31'b0, out_valid}, 32'h0);
        check("R8 reset word", out_word, 32'h0);
        rst_n = 1'b1;
        prefill();

        // R5: identical points give +0
        tick(1, 5, 9, 100, 5, 9, 100, "R5 zero");
        // R3/R4: unit distance encodes 1.0
        tick(1, 1, 0, 0, 0, 0, 0, "R3 one");
        // R1: operand order swapped
        tick(1, 10, 300, 7, 40, 20, 2000, "R1 order a");
        tick(1, 40, 20, 2000, 10, 300, 7, "R1 order b");
        // R2: largest possible total
        tick(1, 0, 0, 0, 2047, 2047, 2047, "R2 max");
        tick(1, 2047, 2047, 2047, 0, 0, 0, "R2 max swap");
        // R4: exact powers of two and a dense fraction
        tick(1, 0, 0, 1024, 0, 0, 0, "R4 pow2");
        tick(1, 3, 5, 7, 0, 0, 0, "R4 small");
        idle(2);
        // R9: stream with gaps and back-to-back pairs
        for (int k = 0; k < 60; k++) begin
            if (k % 7 == 3) idle(1);
            tick(1, int'($urandom_range(0, 2047)), int'($urandom_range(0, 2047)),
                 int'($urandom_range(0, 2047)), int'($urandom_range(0, 2047)),
                 int'($urandom_range(0, 2047)), int'($urandom_range(0, 2047)), "R9 stream");
        end
        idle(5);

        // R8: reset while pairs are in flight discards them
        tick(1, 1, 2, 3, 4, 5, 6, "R8 inflight");
        tick(1, 7, 8, 9, 0, 0, 0, "R8 inflight");
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R8 mid reset valid", {31'b0, out_valid}, 32'h0);
        check("R8 mid reset word", out_word, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        prefill();
        idle(6);
        tick(1, 0, 2, 0, 0, 0, 0, "R3 after reset");
        idle(5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule